// File: doc/BRIEF.md
# Switching Cycle Clock Generator

This block produces the two timing strobes that pace a switching power stage: a one-cycle cycle-start strobe that opens every switching period, and a one-cycle maximum-duty strobe that arrives a fixed number of clock cycles before the next cycle start and forces the high-side phase to end. In the two internal-source modes the block halves an oscillator tick, which runs at twice the switching rate. It also drives a synchronization output at the switching rate so that other converters can follow it.

In the two follower modes the block ignores the oscillator and takes its timing from an external synchronization input. That input first passes a two-stage synchronizer. One follower mode starts a cycle on each rising edge of the input. The other starts a cycle on each falling edge, which puts this converter half a period behind a leader for two-phase interleave. The mode is a two-bit select that stands in for the decoded level of the timing pin.

The maximum-duty strobe is placed from the period measured between the two previous cycle starts, so it needs one complete measured period before it appears. Any change of mode clears the divider and the period measurement. No strobe is issued in the cycle of the change.

Top module: `sw_clkgen`

## Requirements
- R1: While rst_ni is low, cyc_start_o, max_duty_o and sync_o are 0.
- R2: In modes 2'b00 (standalone) and 2'b01 (leader), sync_oe_o is 1 and sync_o toggles one clock after every osc_tick_i pulse. cyc_start_o pulses one clock after each tick that moves sync_o from 0 to 1, which is every second tick.
- R3: In mode 2'b10 (follower, rising), sync_oe_o and sync_o are 0. cyc_start_o pulses exactly 3 clocks after sync_i rises (two synchronizer stages plus the output register). Falling edges start nothing.
- R4: In mode 2'b11 (follower, falling), cyc_start_o pulses exactly 3 clocks after sync_i falls. Rising edges start nothing.
- R5: Let P be the spacing in clocks between the two previous cycle starts. max_duty_o pulses LEAD (default 3) clocks before the instant P clocks after the latest cycle start. No maximum-duty pulse appears before two cycle starts have been seen since reset or since the last mode change.
- R6: The maximum-duty pulse uses the previous period even when the current period differs. If the next cycle start arrives at or before the predicted instant, no maximum-duty pulse is issued for that period.
- R7: A measured period shorter than LEAD+2 clocks produces no maximum-duty pulse.
- R8: A measured period longer than 2**CNT_W-1 clocks (default 1023) is invalid, and no maximum-duty pulse follows it.
- R9: A change of mode_i clears the divider phase and the period measurement. Neither strobe is issued in the change cycle or from state held before it. In the internal-source modes, the first tick after the change starts a cycle.
- R10: cyc_start_o and max_duty_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 00 standalone, 01 leader, 10 follower on rising edge, 11 follower on falling edge |
| osc_tick_i | input | 1 | One-clock pulse per oscillator period (twice the switching rate) |
| sync_i | input | 1 | External synchronization clock, asynchronous |
| sync_o | output | 1 | Synchronization output at the switching rate, 0 in follower modes |
| sync_oe_o | output | 1 | Drive enable for the synchronization pin |
| cyc_start_o | output | 1 | One-clock cycle-start strobe |
| max_duty_o | output | 1 | One-clock maximum-duty strobe, LEAD clocks before the expected next start |

## Verification
The bench targets the divider phase across a mode change. A design that kept the old phase would start the first cycle on the second tick after the change. It also drives period changes in both directions. A design that placed the strobe from the current period, or failed to cancel it when a start came early, would emit strobes at the wrong time or late. Periods just below and above the LEAD+2 floor, and one gap beyond the counter range, expose a missing guard: it shows up as spurious strobes after a short or an overflowed measurement. A mode change while a strobe is pending checks that stale measurement state is dropped. The fixed three-clock latency in both edge polarities catches a wrong synchronizer depth or an inverted edge select.

// File: rtl/sw_clkgen_pkg.sv
`timescale 1ns/1ps
package sw_clkgen_pkg;

  typedef enum logic [1:0] {
    MODE_ALONE    = 2'b00,
    MODE_LEADER   = 2'b01,
    MODE_FOL_RISE = 2'b10,
    MODE_FOL_FALL = 2'b11
  } clk_mode_e;

  function automatic logic mode_is_follower(clk_mode_e m);
    return m[1];
  endfunction

  function automatic logic mode_on_fall(clk_mode_e m);
    return m == MODE_FOL_FALL;
  endfunction

endpackage

// File: rtl/sw_clkgen_edge.sv
`timescale 1ns/1ps
module sw_clkgen_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic fall_sel_i,
  output logic edge_o
);

  // sh_q[STAGES-1] is the synchronized level, sh_q[STAGES] its previous value
  logic [STAGES:0] sh_q;
  logic            cur, prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], sync_i};
  end

  assign cur    = sh_q[STAGES-1];
  assign prev   = sh_q[STAGES];
  assign edge_o = fall_sel_i ? (prev & ~cur) : (cur & ~prev);

  // R3 R4: same-polarity edges cannot occur on consecutive cycles
  a_r3_edge_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_o && $stable(fall_sel_i)) |=> !(edge_o && $stable(fall_sel_i)));

endmodule

// File: rtl/sw_clkgen_div.sv
`timescale 1ns/1ps
module sw_clkgen_div (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic tick_i,
  output logic phase_o,
  output logic start_o
);

  logic phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              phase_q <= 1'b0;
    else if (clr_i)           phase_q <= 1'b0;
    else if (en_i && tick_i)  phase_q <= ~phase_q;
  end

  assign phase_o = phase_q;
  assign start_o = en_i & tick_i & ~phase_q;

  a_r2_tick_toggles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(en_i && tick_i && !clr_i) |-> (phase_q != $past(phase_q)));

  a_r9_clear_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clr_i) |-> !phase_q);

endmodule

// File: rtl/sw_clkgen_meter.sv
`timescale 1ns/1ps
module sw_clkgen_meter #(
  parameter int CNT_W = 10,
  parameter int LEAD  = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic trig_i,
  output logic md_o
);

  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] PER_MIN  = CNT_W'(LEAD + 2);
  localparam logic [CNT_W-1:0] LEAD_OFS = CNT_W'(LEAD + 1);

  logic [CNT_W-1:0] cnt_q, per_q;
  logic             seen_q, valid_q, md_q, match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      per_q   <= '0;
      seen_q  <= 1'b0;
      valid_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q   <= '0;
      per_q   <= '0;
      seen_q  <= 1'b0;
      valid_q <= 1'b0;
    end else if (trig_i) begin
      cnt_q   <= '0;
      seen_q  <= 1'b1;
      valid_q <= seen_q && (cnt_q != CNT_MAX);
      if (seen_q) per_q <= cnt_q + CNT_W'(1);
    end else if (cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // fire LEAD cycles before the predicted next start
  assign match = valid_q && !trig_i && (per_q >= PER_MIN) &&
                 (cnt_q == per_q - LEAD_OFS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    md_q <= 1'b0;
    else if (clr_i) md_q <= 1'b0;
    else            md_q <= match;
  end

  assign md_o = md_q;

  a_r5_needs_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    md_o |-> $past(valid_q));

  a_r7_min_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    md_o |-> ($past(per_q) >= PER_MIN));

  a_r8_overflow_invalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(trig_i && !clr_i && cnt_q == CNT_MAX) |-> !valid_q);

endmodule

// File: rtl/sw_clkgen.sv
`timescale 1ns/1ps
module sw_clkgen
  import sw_clkgen_pkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int LEAD        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       osc_tick_i,
  input  logic       sync_i,
  output logic       sync_o,
  output logic       sync_oe_o,
  output logic       cyc_start_o,
  output logic       max_duty_o
);

  clk_mode_e mode_q;
  logic      chg, follower, ext_edge, div_start, div_phase, trig, start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_ALONE;
    else         mode_q <= clk_mode_e'(mode_i);
  end

  assign chg      = (clk_mode_e'(mode_i) != mode_q);
  assign follower = mode_is_follower(mode_q);

  sw_clkgen_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_i     (sync_i),
    .fall_sel_i (mode_on_fall(mode_q)),
    .edge_o     (ext_edge)
  );

  sw_clkgen_div u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (chg),
    .en_i    (~follower),
    .tick_i  (osc_tick_i),
    .phase_o (div_phase),
    .start_o (div_start)
  );

  assign trig = ~chg & (follower ? ext_edge : div_start);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) start_q <= 1'b0;
    else         start_q <= trig;
  end

  sw_clkgen_meter #(.CNT_W(CNT_W), .LEAD(LEAD)) u_meter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (chg),
    .trig_i (trig),
    .md_o   (max_duty_o)
  );

  assign cyc_start_o = start_q;
  assign sync_o      = ~follower & div_phase;
  assign sync_oe_o   = ~follower;

  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (!cyc_start_o && !max_duty_o && !sync_o));

  a_r10_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cyc_start_o && max_duty_o));

  a_r3_follower_sync_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    follower |-> (!sync_o && !sync_oe_o));

  a_r2_start_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!follower && cyc_start_o && $stable(mode_q)) |-> (sync_o && !$past(sync_o)));

  a_r9_quiet_on_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != $past(mode_q)) |-> (!cyc_start_o && !max_duty_o));

endmodule

// File: tb/sw_clkgen_test.sv
`timescale 1ns/1ps
module sw_clkgen_test;

  localparam int LEAD = 3;
  localparam int MAXP = 1023;
  localparam int LAT  = 3;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic       osc_tick_i = 1'b0;
  logic       sync_i = 1'b0;
  logic       sync_o, sync_oe_o, cyc_start_o, max_duty_o;

  sw_clkgen uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .mode_i      (mode_i),
    .osc_tick_i  (osc_tick_i),
    .sync_i      (sync_i),
    .sync_o      (sync_o),
    .sync_oe_o   (sync_oe_o),
    .cyc_start_o (cyc_start_o),
    .max_duty_o  (max_duty_o)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nchk = 0, nerr = 0;
  int st[64], md[64], exp_st[64];
  int ns, nm, ne, tog, oe_bad, end_c;
  bit logging = 0, want_oe = 0, last_sync = 0;

  always @(negedge clk) begin
    if (logging) begin
      if (cyc_start_o && ns < 64) begin st[ns] = cyc; ns++; end
      if (max_duty_o && nm < 64)  begin md[nm] = cyc; nm++; end
      if (sync_o != last_sync) tog++;
      last_sync = sync_o;
      if (want_oe ? !sync_oe_o : (sync_oe_o || sync_o)) oe_bad++;
    end
  end

  task automatic chk(bit ok, string tag, int act, int expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic begin_log(bit oe);
    ns = 0; nm = 0; ne = 0; tog = 0; oe_bad = 0;
    want_oe = oe; last_sync = sync_o; logging = 1;
  endtask

  task automatic end_log();
    logging = 0;
    end_c = cyc;
  endtask

  task automatic osc(int n, int gap);
    for (int i = 0; i < n; i++) begin
      osc_tick_i = 1'b1;
      if (i % 2 == 0) begin exp_st[ne] = cyc + 1; ne++; end
      step(1);
      osc_tick_i = 1'b0;
      step(gap - 1);
    end
  endtask

  task automatic pulse(int h, int l, bit fall);
    sync_i = 1'b1;
    if (!fall) begin exp_st[ne] = cyc + LAT; ne++; end
    step(h);
    sync_i = 1'b0;
    if (fall) begin exp_st[ne] = cyc + LAT; ne++; end
    step(l);
  endtask

  task automatic pulses(int n, int h, int l, bit fall);
    for (int i = 0; i < n; i++) pulse(h, l, fall);
  endtask

  // clear measurement with a brief mode excursion while sync_i is steady low
  task automatic flip_mode(logic [1:0] m);
    mode_i = m ^ 2'b01;
    step(2);
    mode_i = m;
    step(2);
  endtask

  task automatic check_starts(string tag);
    chk(ns == ne, {tag, " start count"}, ns, ne);
    for (int k = 0; k < ne && k < ns; k++)
      chk(st[k] == exp_st[k], {tag, " start time"}, st[k], exp_st[k]);
  endtask

  task automatic check_md(string tag);
    int e;
    e = 0;
    for (int k = 1; k < ns; k++) begin
      int p;
      int t;
      bit due;
      p = st[k] - st[k-1];
      t = st[k] + p - LEAD;
      due = (p >= LEAD + 2) && (p <= MAXP) &&
            ((k + 1 < ns) ? (t < st[k+1]) : (t < end_c));
      if (due) begin
        chk(e < nm && md[e] == t, {tag, " max-duty time"}, (e < nm) ? md[e] : -1, t);
        e++;
      end
    end
    chk(nm == e, {tag, " max-duty count"}, nm, e);
  endtask

  initial begin
    #1_000_000;
    nchk++; nerr++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    step(3);
    // R1: outputs quiet in reset
    chk(!cyc_start_o, "R1 cyc_start", cyc_start_o, 0);
    chk(!max_duty_o, "R1 max_duty", max_duty_o, 0);
    chk(!sync_o, "R1 sync_o", sync_o, 0);
    rst_ni = 1'b1;
    step(2);

    // R2 R5: standalone, odd tick count leaves divider phase at 1
    begin_log(1);
    osc(9, 4);
    step(10);
    end_log();
    check_starts("R2");
    chk(tog == 9, "R2 sync toggles", tog, 9);
    chk(oe_bad == 0, "R2 sync enable", oe_bad, 0);
    check_md("R5");

    // R9: leader mode after change, first tick must start a cycle
    mode_i = 2'b01;
    step(2);
    begin_log(1);
    osc(10, 6);
    step(14);
    end_log();
    check_starts("R9");
    chk(tog == 10, "R2 sync toggles leader", tog, 10);
    check_md("R5");

    // R3: follower on rising edge
    mode_i = 2'b10;
    step(4);
    begin_log(0);
    pulses(8, 8, 12, 0);
    end_log();
    check_starts("R3");
    chk(oe_bad == 0, "R3 sync output off", oe_bad, 0);
    check_md("R5");

    // R6: period changes, longer then much shorter
    flip_mode(2'b10);
    begin_log(0);
    pulses(3, 8, 12, 0);
    pulses(2, 8, 22, 0);
    pulses(2, 4, 4, 0);
    pulses(3, 8, 12, 0);
    end_log();
    check_starts("R6");
    check_md("R6");

    // R7: periods below the floor, then at the floor
    flip_mode(2'b10);
    begin_log(0);
    pulses(6, 2, 2, 0);
    step(20);
    end_log();
    check_starts("R7");
    chk(nm == 0, "R7 no max-duty", nm, 0);
    flip_mode(2'b10);
    begin_log(0);
    pulses(5, 3, 2, 0);
    step(20);
    end_log();
    check_starts("R7");
    check_md("R7");

    // R8: one gap beyond the counter range
    flip_mode(2'b10);
    begin_log(0);
    pulses(3, 8, 12, 0);
    pulse(8, 1100, 0);
    pulses(3, 8, 12, 0);
    end_log();
    check_starts("R8");
    check_md("R8");

    // R9: mode change with a strobe pending
    flip_mode(2'b10);
    begin_log(0);
    pulses(3, 8, 12, 0);
    pulse(8, 5, 0);
    end_log();
    check_starts("R9");
    mode_i = 2'b11;
    begin_log(0);
    step(30);
    end_log();
    chk(ns == 0, "R9 no start after change", ns, 0);
    chk(nm == 0, "R9 no max-duty after change", nm, 0);

    // R4: follower on falling edge
    begin_log(0);
    pulses(6, 8, 12, 1);
    end_log();
    check_starts("R4");
    chk(oe_bad == 0, "R4 sync output off", oe_bad, 0);
    check_md("R4");

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule